// File: doc/BRIEF.md
# Management Frame Master for Ethernet PHYs

This block builds station-management frames on a two-wire interface made of a clock line and a bidirectional data line. It takes one request at a time on a valid/ready handshake. A request holds a direction flag, a 5-bit PHY address, a 5-bit register number and, for writes, 16 bits of data. The block then plays out the whole frame. It produces a divided management clock, drives or releases the data line, and collects read data from the PHY.

Every frame opens with 32 clock periods of ones and closes with another 32 periods of ones. A write sends a 32-bit command word. A read sends only the 14 header bits, then releases the line for one turnaround period, then samples 16 data bits. When the closing run of ones has been sent, `rsp_done` pulses for one cycle and `rsp_rdata` carries the last word read. The parameter `DIV` sets how many system cycles each half of the management clock lasts. It must be at least 3.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and whenever no frame is in progress, `mdc` is low, `mdio_oe` is 1, `mdio_o` is 1, `req_ready` is 1 and `rsp_done` is 0. Reset asserted in the middle of a frame returns all of these at once.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low until the frame ends, and any request presented meanwhile has no effect on the frame.
- R3: During a frame, each low and each high phase of `mdc` lasts exactly `DIV` system cycles. Between frames `mdc` stays low.
- R4: Each frame starts with 32 `mdc` periods during which the line is driven with `mdio_o`=1.
- R5: A write sends 32 bits, MSB first, one per `mdc` period. From most to least significant the bits are: 0, 1, 0, 1, five PHY address bits, five register bits, 1, 0, then the 16 write-data bits.
- R6: A read drives only the first 14 bits: 0, 1, 1, 0, the address and the register. It then holds `mdio_oe` at 0 for 17 periods: one turnaround period followed by 16 data periods.
- R7: `mdio_o` and `mdio_oe` change only at the cycle in which `mdc` falls (or at request acceptance while `mdc` is low). They are constant while `mdc` is high.
- R8: For a read, `mdio_i` passes through a two-flop synchronizer. One bit is taken at each rising `mdc` edge of the 16 data periods, MSB first, and the resulting word appears on `rsp_rdata` in the cycle in which `rsp_done` is high.
- R9: After the data phase the line is driven again, and 32 more periods of `mdio_o`=1 are sent before the frame ends.
- R10: `rsp_done` is a single-cycle pulse that rises, together with `req_ready`, exactly 2·DIV·N system cycles after the accept edge. N is 95 for a read and 96 for a write. A write leaves `rsp_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_read | input | 1 | 1 = read frame, 0 = write frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register number |
| req_wdata | input | 16 | Data for a write |
| rsp_done | output | 1 | One-cycle end-of-frame pulse |
| rsp_rdata | output | 16 | Last word read from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Outgoing data level |
| mdio_oe | output | 1 | 1 = drive the data line, 0 = release it |
| mdio_i | input | 1 | Sampled level of the data line |

## Verification
The assertions assume the request fields stay steady only in the accept cycle. They also assume that `mdio_i` is asynchronous and carries meaning only while the line is released. The bench's PHY model changes `mdio_i` only just after a falling `mdc` and only while `mdio_oe` is 0. With `DIV` = 4 this gives the synchronizer more than two cycles before each rising edge. Requests are raised only at negative clock edges, and one test deliberately holds a second request high through a busy frame to confirm that it is refused.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int WORD_W    = 32;
  localparam int PRE_LEN   = 32;
  localparam int POST_LEN  = 32;
  localparam int RD_HDR    = 14;
  localparam int TA_LEN    = 1;
  localparam int BCNT_W    = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_CMD,
    PH_TURN,
    PH_DATA,
    PH_POST
  } mdio_phase_e;

  // Command word, transmitted MSB first: unused 0, start 1, read flag,
  // write flag, address, register, turnaround 1 0, write data.
  function automatic logic [WORD_W-1:0] mdio_word(
    input logic              rd,
    input logic [PHY_W-1:0]  phy,
    input logic [REG_W-1:0]  rnum,
    input logic [DATA_W-1:0] wd
  );
    mdio_word = {1'b0, 1'b1, rd, ~rd, phy, rnum, 2'b10, wd};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;
  logic          wrap;

  assign wrap = run && (cnt_q == LAST);
  assign rise = wrap && !half_q;
  assign fall = wrap && half_q;
  assign mdc  = half_q;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (!run) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      half_d = ~half_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  AST_PHASE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3

  AST_STOP_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc); // R3

endmodule

// File: rtl/mdio_sync.sv
module mdio_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b1;
      ff2_q <= 1'b1;
    end else begin
      ff1_q <= din;
      ff2_q <= ff1_q;
    end
  end

  assign dout = ff2_q;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              rise,
  input  logic              fall,
  input  logic              din_sync,
  output logic              run,
  output logic              dout,
  output logic              oe,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  mdio_phase_e        ph_q, ph_d;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic [BCNT_W-1:0]  span;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [DATA_W-1:0]  cap_q, cap_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               rd_q, rd_d;
  logic               dout_q, dout_d;
  logic               oe_q, oe_d;
  logic               done_q, done_d;
  logic               last;

  always_comb begin
    case (ph_q)
      PH_PRE:  span = BCNT_W'(PRE_LEN);
      PH_CMD:  span = rd_q ? BCNT_W'(RD_HDR) : BCNT_W'(WORD_W);
      PH_TURN: span = BCNT_W'(TA_LEN);
      PH_DATA: span = BCNT_W'(DATA_W);
      default: span = BCNT_W'(POST_LEN);
    endcase
  end

  assign last = (bcnt_q == span - 1'b1);

  always_comb begin
    ph_d    = ph_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    cap_d   = cap_q;
    rdata_d = rdata_q;
    rd_d    = rd_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    done_d  = 1'b0;

    if (ph_q == PH_IDLE) begin
      if (req_valid) begin
        ph_d   = PH_PRE;
        bcnt_d = '0;
        sh_d   = mdio_word(req_read, req_phy, req_reg, req_wdata);
        rd_d   = req_read;
        dout_d = 1'b1;
        oe_d   = 1'b1;
      end
    end else begin
      if (rise && ph_q == PH_DATA) begin
        cap_d = {cap_q[DATA_W-2:0], din_sync};
      end
      if (fall) begin
        bcnt_d = last ? '0 : bcnt_q + 1'b1;
        case (ph_q)
          PH_PRE: begin
            if (last) begin
              ph_d   = PH_CMD;
              dout_d = sh_q[WORD_W-1];
              sh_d   = {sh_q[WORD_W-2:0], 1'b0};
            end
          end
          PH_CMD: begin
            if (!last) begin
              dout_d = sh_q[WORD_W-1];
              sh_d   = {sh_q[WORD_W-2:0], 1'b0};
            end else if (rd_q) begin
              ph_d = PH_TURN;
              oe_d = 1'b0;
            end else begin
              ph_d   = PH_POST;
              dout_d = 1'b1;
            end
          end
          PH_TURN: begin
            if (last) ph_d = PH_DATA;
          end
          PH_DATA: begin
            if (last) begin
              ph_d    = PH_POST;
              oe_d    = 1'b1;
              dout_d  = 1'b1;
              rdata_d = cap_q;
            end
          end
          default: begin
            if (last) begin
              ph_d   = PH_IDLE;
              done_d = 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      bcnt_q  <= '0;
      sh_q    <= '0;
      cap_q   <= '0;
      rdata_q <= '0;
      rd_q    <= 1'b0;
      dout_q  <= 1'b1;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
      cap_q   <= cap_d;
      rdata_q <= rdata_d;
      rd_q    <= rd_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
    end
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign run       = (ph_q != PH_IDLE);
  assign dout      = dout_q;
  assign oe        = oe_q;
  assign rdata     = rdata_q;
  assign done      = done_q;

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> rd_q); // R6

  AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    run && !rd_q |=> $stable(rdata)); // R10

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_read,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic run, rise, fall, din_sync;

  mdio_clkgen #(.DIV(DIV)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mdio_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mdio_i),
    .dout  (din_sync)
  );

  mdio_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_read  (req_read),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rise      (rise),
    .fall      (fall),
    .din_sync  (din_sync),
    .run       (run),
    .dout      (mdio_o),
    .oe        (mdio_oe),
    .rdata     (rsp_rdata),
    .done      (rsp_done)
  );

  AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o) && $stable(mdio_oe)); // R7

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mdc && mdio_oe && mdio_o); // R1

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready); // R10

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int DIV  = 4;
  localparam int NVEC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_read = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mdio_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // {read, phy[4:0], reg[4:0], wdata[15:0], phy_response[15:0]}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b1, 5'h01, 5'h02, 16'h0000, 16'hA5C3},
    {1'b0, 5'h1F, 5'h00, 16'h8001, 16'h0000},
    {1'b1, 5'h00, 5'h1F, 16'h0000, 16'h0001},
    {1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0000},
    {1'b1, 5'h0A, 5'h15, 16'h0000, 16'h8000},
    {1'b1, 5'h12, 5'h04, 16'h0000, 16'h7FFE}
  };

  // PHY model and line monitor, evaluated between clock edges
  logic [127:0] cap;
  int           ncap, nrel, k, ph_cnt, phase_err;
  logic         prev_mdc, fresh;
  logic [15:0]  resp;

  initial begin
    cap = '0; ncap = 0; nrel = 0; k = 0; ph_cnt = 0; phase_err = 0;
    prev_mdc = 1'b0; fresh = 1'b1; resp = '0;
  end

  always @(negedge clk) begin
    ph_cnt = ph_cnt + 1;
    if (!prev_mdc && mdc) begin
      if (!fresh && ph_cnt != DIV) phase_err = phase_err + 1;
      ph_cnt = 0;
      fresh = 1'b0;
      if (mdio_oe) begin
        cap = {cap[126:0], mdio_o};
        ncap = ncap + 1;
      end else begin
        nrel = nrel + 1;
      end
    end
    if (prev_mdc && !mdc) begin
      if (ph_cnt != DIV) phase_err = phase_err + 1;
      ph_cnt = 0;
      if (!mdio_oe) begin
        mdio_i = (k == 0) ? 1'b0 : resp[16-k];
        k = k + 1;
      end
    end
    if (mdio_oe) begin
      k = 0;
      mdio_i = 1'b1;
    end
    if (req_ready) fresh = 1'b1;
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap = '0;
    ncap = 0;
    nrel = 0;
  endtask

  function automatic logic [31:0] word_of(input logic rd, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
    word_of = {1'b0, 1'b1, rd, !rd, p, r, 2'b10, d};
  endfunction

  function automatic logic [127:0] stream_of(input logic rd, input logic [31:0] w);
    if (rd) stream_of = {50'b0, 32'hFFFF_FFFF, w[31:18], 32'hFFFF_FFFF};
    else    stream_of = {32'b0, 32'hFFFF_FFFF, w, 32'hFFFF_FFFF};
  endfunction

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!rsp_done) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [15:0] rsp_word,
                           output int cyc);
    resp = rsp_word;
    clear_mon();
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_phy = p; req_reg = r; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R2", "ready after accept", 128'(req_ready), 128'd0);
    wait_done(cyc);
  endtask

  logic [15:0] last_rd;
  int          cyc;

  initial begin
    last_rd = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    check({mdc, mdio_oe, mdio_o, req_ready, rsp_done} == 5'b01110, "R1", "reset outputs",
          128'({mdc, mdio_oe, mdio_o, req_ready, rsp_done}), 128'b01110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({mdc, mdio_oe, mdio_o, req_ready} == 4'b0111, "R1", "idle after reset",
          128'({mdc, mdio_oe, mdio_o, req_ready}), 128'b0111);

    // Vector table: R4 R5 R6 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      logic        vrd;
      logic [31:0] w;
      vrd = VEC[i][42];
      w = word_of(vrd, VEC[i][41:37], VEC[i][36:32], VEC[i][31:16]);
      run_frame(vrd, VEC[i][41:37], VEC[i][36:32], VEC[i][31:16], VEC[i][15:0], cyc);
      check(cyc == 2 * DIV * (vrd ? 95 : 96), "R10", "frame length", 128'(cyc),
            128'(2 * DIV * (vrd ? 95 : 96)));
      check(req_ready == 1'b1, "R10", "ready with done", 128'(req_ready), 128'd1);
      check(ncap == (vrd ? 78 : 96), "R4", "driven period count", 128'(ncap),
            128'(vrd ? 78 : 96));
      check(cap == stream_of(vrd, w), vrd ? "R6" : "R5", "driven bit stream incl R9 trailer",
            cap, stream_of(vrd, w));
      check(nrel == (vrd ? 17 : 0), "R6", "released periods", 128'(nrel),
            128'(vrd ? 17 : 0));
      if (vrd) last_rd = VEC[i][15:0];
      check(rsp_rdata == last_rd, vrd ? "R8" : "R10", "read data", 128'(rsp_rdata),
            128'(last_rd));
      @(negedge clk);
      check(rsp_done == 1'b0, "R10", "done width", 128'(rsp_done), 128'd0);
      check({mdio_oe, mdio_o} == 2'b11, "R9", "line driven after frame",
            128'({mdio_oe, mdio_o}), 128'b11);
    end
    check(phase_err == 0, "R3", "mdc phase lengths", 128'(phase_err), 128'd0);

    // R2: second request held during a busy frame is ignored
    clear_mon();
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_phy = 5'h03; req_reg = 5'h05; req_wdata = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    req_read = 1'b1; req_phy = 5'h1C; req_reg = 5'h11; req_wdata = 16'hDEAD;
    wait_done(cyc);
    req_valid = 1'b0;
    check(cap == stream_of(1'b0, word_of(1'b0, 5'h03, 5'h05, 16'h1234)), "R2",
          "busy request ignored", cap, stream_of(1'b0, word_of(1'b0, 5'h03, 5'h05, 16'h1234)));
    clear_mon();
    repeat (4 * DIV) @(negedge clk);
    check(ncap == 0 && mdc == 1'b0 && req_ready, "R3", "no clock while idle",
          128'(ncap), 128'd0);

    // R1: reset in mid-frame
    resp = 16'h5555;
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b1; req_phy = 5'h07; req_reg = 5'h01;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (37 * 2 * DIV) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({mdc, mdio_oe, mdio_o, req_ready, rsp_done} == 5'b01110, "R1", "mid-frame reset",
          128'({mdc, mdio_oe, mdio_o, req_ready, rsp_done}), 128'b01110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_frame(1'b1, 5'h07, 5'h01, 16'h0, 16'h5A0F, cyc);
    check(rsp_rdata == 16'h5A0F, "R8", "read after reset", 128'(rsp_rdata), 128'h5A0F);
    check(cyc == 2 * DIV * 95, "R10", "frame length after reset", 128'(cyc), 128'(2 * DIV * 95));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule